// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block turns a small set of external interrupt pins (six by default) into one interrupt request per line. Each pin first passes through a two-flop synchroniser. A per-line detector then qualifies the pin in one of five trigger modes: active-high level, active-low level, rising edge, falling edge or either edge. In the edge modes a sticky latch holds the request until software acknowledges it with a write-one clear. In the level modes the request simply follows the synchronised pin. A per-line enable gates each request before it leaves the block. The request can drive a processor interrupt input directly, or feed one input of an internal interrupt controller.

Software programs the unit through 32-bit configuration words on a plain register bus with separate read and write strobes. Each word serves four lines. The line index divided by four picks the word, and the index modulo four picks the bit inside each field. A line that has not been programmed behaves as an active-low level input.

Top module: `xirq_unit`

## Requirements
- R1: After reset every request is low. Configuration word 0 reads 0x0000F000 and word 1 reads 0x00003000. This means level-select=1, sense=0, both-edges=0 and enable=0, so every line defaults to active-low level.
- R2: With level-select=1 and sense=1 (active-high level), a line's request follows its pin. The request rises on the second rising clock edge after the pin changes, not on the first.
- R3: With level-select=1 and sense=0 (active-low level), a line's request is the inverse of its synchronised pin.
- R4: With level-select=0, both-edges=0 and sense=1, a rising pin edge sets the line's latch. The request appears on the third clock edge after the pin change and stays set after the pin falls again.
- R5: With level-select=0, both-edges=0 and sense=0, only a falling edge sets the latch; a rising edge does not.
- R6: With level-select=0 and both-edges=1, an edge in either direction sets the latch.
- R7: A line's request is high only while its enable bit is 1. An edge captured while the line is disabled is kept, and shows on the request once the line is enabled.
- R8: Writing 1 to a line's clear bit drops its latched edge request at that write. In the level modes a clear has no lasting effect on the request.
- R9: If a clear write and a new qualifying edge fall in the same clock cycle, the edge wins and the request stays set.
- R10: Word layout, with bit j = line index modulo 4 and word = line index / 4: clear at bit j, sense at 4+j, both-edges at 8+j, level-select at 12+j and enable at 16+j. Clear bits always read 0. Bits of absent lines and addresses without a word read 0. Read data is registered and valid one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_LINES | Raw external interrupt pins |
| bus_addr_i | input | ADDR_W | Word address of the configuration register |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_LINES | Interrupt request per line |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as a fresh edge on an already latched line. The new edge only becomes visible two synchroniser stages and one compare stage after the pin moves. The bench puts a line in either-edge mode and latches a rising edge. It then drops the pin and issues the clear write exactly two cycles later, so the write strobe meets the falling-edge detection, and it expects the request to stay high. A second clear alone must then drop the request. Masked capture and the mapping of lines 4 and 5 into the second word are also reached only through ordered sequences of bus writes and pin moves.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int GRP       = 4;
  localparam int FLD_CLR   = 0;
  localparam int FLD_SENSE = 4;
  localparam int FLD_BOTH  = 8;
  localparam int FLD_LEVEL = 12;
  localparam int FLD_MASK  = 16;

  typedef struct packed {
    logic level;
    logic sense;
    logic both;
    logic mask;
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{level: 1'b1, sense: 1'b0, both: 1'b0, mask: 1'b0};

  typedef enum logic [2:0] {
    TRIG_LVL_HI,
    TRIG_LVL_LO,
    TRIG_RISE,
    TRIG_FALL,
    TRIG_BOTH
  } trig_e;

  function automatic trig_e decode_trig(line_cfg_t c);
    if (c.level) return c.sense ? TRIG_LVL_HI : TRIG_LVL_LO;
    if (c.both)  return TRIG_BOTH;
    return c.sense ? TRIG_RISE : TRIG_FALL;
  endfunction

  function automatic logic edge_seen(trig_e m, logic cur, logic prev);
    case (m)
      TRIG_RISE: return cur & ~prev;
      TRIG_FALL: return ~cur & prev;
      TRIG_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic level_seen(trig_e m, logic cur);
    case (m)
      TRIG_LVL_HI: return cur;
      TRIG_LVL_LO: return ~cur;
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= '0;
    else        pipe_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[s] <= '0;
      else        pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/xirq_line.sv
module xirq_line
  import xirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_s_i,
  input  line_cfg_t cfg_i,
  input  logic      clr_i,
  output logic      active_o,
  output logic      edge_evt_o,
  output logic      latch_o
);

  logic  prev_q;
  logic  latch_q;
  logic  latch_d;
  logic  edge_mode;
  trig_e trig;

  assign trig       = decode_trig(cfg_i);
  assign edge_mode  = ~cfg_i.level;
  assign edge_evt_o = edge_mode & edge_seen(trig, pin_s_i, prev_q);

  always_comb begin
    latch_d = latch_q;
    if (!edge_mode)      latch_d = 1'b0;
    else if (edge_evt_o) latch_d = 1'b1;
    else if (clr_i)      latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= pin_s_i;
      latch_q <= latch_d;
    end
  end

  assign latch_o  = latch_q;
  assign active_o = edge_mode ? latch_q : level_seen(trig, pin_s_i);

  // R4, R5, R6: a qualifying edge sets the latch
  p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt_o |=> latch_q);
  // R9: an edge in the same cycle as a clear still leaves the latch set
  p_edge_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt_o && clr_i) |=> latch_q);
  // R8: a clear with no new edge drops the latch
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && clr_i && !edge_evt_o) |=> !latch_q);
  // R4: a latched edge holds until cleared
  p_latch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && latch_q && !clr_i) |=> latch_q);
  // R2, R3: level modes never leave a latched request behind
  p_level_no_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> !latch_q);

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 6,
  parameter int ADDR_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           wr_i,
  input  logic [31:0]                    wdata_i,
  input  logic                           rd_i,
  output logic [31:0]                    rdata_o,
  output line_cfg_t [NUM_LINES-1:0]      cfg_o,
  output logic [NUM_LINES-1:0]           clr_o
);

  localparam int NUM_REGS = (NUM_LINES + GRP - 1) / GRP;

  logic [31:0] rd_next;
  logic        addr_valid;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int WORD = i / GRP;
    localparam int POS  = i % GRP;
    logic sel;
    assign sel      = (addr_i == ADDR_W'(WORD));
    assign clr_o[i] = wr_i & sel & wdata_i[FLD_CLR + POS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[i] <= CFG_RESET;
      end else if (wr_i && sel) begin
        cfg_o[i].sense <= wdata_i[FLD_SENSE + POS];
        cfg_o[i].both  <= wdata_i[FLD_BOTH  + POS];
        cfg_o[i].level <= wdata_i[FLD_LEVEL + POS];
        cfg_o[i].mask  <= wdata_i[FLD_MASK  + POS];
      end
    end
  end

  assign addr_valid = (int'(addr_i) < NUM_REGS);

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (addr_valid && addr_i == ADDR_W'(i / GRP)) begin
        rd_next[FLD_SENSE + i % GRP] = cfg_o[i].sense;
        rd_next[FLD_BOTH  + i % GRP] = cfg_o[i].both;
        rd_next[FLD_LEVEL + i % GRP] = cfg_o[i].level;
        rd_next[FLD_MASK  + i % GRP] = cfg_o[i].mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_next;
  end

  // R10: clear bits read back as zero
  p_clear_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (rdata_o[FLD_CLR +: GRP] == '0));
  // R10: read data changes only after a read strobe
  p_rdata_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
  import xirq_pkg::*;
#(
  parameter int NUM_LINES   = 6,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic [31:0]          bus_wdata_i,
  input  logic                 bus_rd_i,
  output logic [31:0]          bus_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);

  line_cfg_t [NUM_LINES-1:0] cfg;
  logic [NUM_LINES-1:0]      clr;
  logic [NUM_LINES-1:0]      pin_s;
  logic [NUM_LINES-1:0]      active;
  logic [NUM_LINES-1:0]      edge_evt;
  logic [NUM_LINES-1:0]      latch;

  xirq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  xirq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .wdata_i (bus_wdata_i),
    .rd_i    (bus_rd_i),
    .rdata_o (bus_rdata_o),
    .cfg_o   (cfg),
    .clr_o   (clr)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    xirq_line u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_s_i    (pin_s[i]),
      .cfg_i      (cfg[i]),
      .clr_i      (clr[i]),
      .active_o   (active[i]),
      .edge_evt_o (edge_evt[i]),
      .latch_o    (latch[i])
    );
    assign irq_o[i] = active[i] & cfg[i].mask;

    // R7: a latched edge on a disabled line is kept
    p_masked_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg[i].mask && latch[i] && !clr[i] && !cfg[i].level && !bus_wr_i) |=> latch[i]);
  end

endmodule

// File: tb/xirq_unit_test.sv
module xirq_unit_test;

  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic [N-1:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] shadow [2];

  always #10 clk = ~clk;

  xirq_unit uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rd_i(rd),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    addr = a[1:0]; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    addr = a[1:0]; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic cfg_line(int ln, bit lvl, bit sns, bit bth, bit msk);
    int w = ln / 4;
    int j = ln % 4;
    shadow[w][4 + j]  = sns;
    shadow[w][8 + j]  = bth;
    shadow[w][12 + j] = lvl;
    shadow[w][16 + j] = msk;
    bus_write(w, shadow[w]);
  endtask

  task automatic clear_line(int ln);
    bus_write(ln / 4, shadow[ln / 4] | (32'd1 << (ln % 4)));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq after reset", 32'(irq), 32'h0);
    bus_read(0, d); check("R1 word0 reset", d, 32'h0000F000);
    bus_read(1, d); check("R1 word1 reset", d, 32'h00003000);
  endtask

  task automatic t_level_high;
    cfg_line(0, 1, 1, 0, 1);
    check("R2 idle low", 32'(irq[0]), 0);
    pins[0] = 1'b1;
    tick(1); check("R2 not after one edge", 32'(irq[0]), 0);
    tick(1); check("R2 follows pin high", 32'(irq[0]), 1);
    pins[0] = 1'b0;
    tick(2); check("R2 follows pin low", 32'(irq[0]), 0);
  endtask

  task automatic t_level_low;
    cfg_line(1, 1, 0, 0, 1);
    check("R3 low pin requests", 32'(irq[1]), 1);
    pins[1] = 1'b1;
    tick(2); check("R3 high pin quiet", 32'(irq[1]), 0);
    pins[1] = 1'b0;
    tick(2); check("R3 low again", 32'(irq[1]), 1);
    cfg_line(1, 1, 0, 0, 0);
    check("R7 disable drops level request", 32'(irq[1]), 0);
  endtask

  task automatic t_rise;
    cfg_line(5, 0, 1, 0, 1);
    pins[5] = 1'b1;
    tick(2); check("R4 not before third edge", 32'(irq[5]), 0);
    tick(1); check("R4 rising latched", 32'(irq[5]), 1);
    pins[5] = 1'b0;
    tick(3); check("R4 held after pin falls", 32'(irq[5]), 1);
    clear_line(5);
    check("R8 clear drops edge", 32'(irq[5]), 0);
  endtask

  task automatic t_fall;
    cfg_line(2, 0, 0, 0, 0);
    pins[2] = 1'b1;
    tick(3);
    cfg_line(2, 0, 0, 0, 1);
    check("R5 rise ignored", 32'(irq[2]), 0);
    pins[2] = 1'b0;
    tick(3); check("R5 falling latched", 32'(irq[2]), 1);
    clear_line(2);
    check("R8 clear falling", 32'(irq[2]), 0);
  endtask

  task automatic t_both;
    cfg_line(4, 0, 0, 1, 1);
    pins[4] = 1'b1;
    tick(3); check("R6 rise latched", 32'(irq[4]), 1);
    clear_line(4);
    check("R6 cleared", 32'(irq[4]), 0);
    pins[4] = 1'b0;
    tick(3); check("R6 fall latched", 32'(irq[4]), 1);
    clear_line(4);
    check("R6 cleared again", 32'(irq[4]), 0);
  endtask

  task automatic t_mask;
    cfg_line(3, 0, 1, 0, 0);
    pins[3] = 1'b1;
    tick(3); check("R7 disabled line quiet", 32'(irq[3]), 0);
    cfg_line(3, 0, 1, 0, 1);
    check("R7 captured edge shown on enable", 32'(irq[3]), 1);
    clear_line(3);
    check("R7 cleared", 32'(irq[3]), 0);
  endtask

  task automatic t_clear_level;
    cfg_line(0, 1, 1, 0, 1);
    pins[0] = 1'b1;
    tick(2); check("R8 level high", 32'(irq[0]), 1);
    clear_line(0);
    check("R8 clear no effect in level", 32'(irq[0]), 1);
    tick(1); check("R8 still high", 32'(irq[0]), 1);
    pins[0] = 1'b0;
    tick(2);
  endtask

  task automatic t_race;
    cfg_line(4, 0, 0, 1, 1);
    pins[4] = 1'b1;
    tick(3); check("R9 first edge latched", 32'(irq[4]), 1);
    pins[4] = 1'b0;
    tick(2);
    clear_line(4);
    check("R9 edge beats clear", 32'(irq[4]), 1);
    clear_line(4);
    check("R9 lone clear drops", 32'(irq[4]), 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    bus_read(0, d); check("R10 word0 readback", d, shadow[0]);
    bus_write(1, 32'hFFFFFFFF);
    shadow[1] = 32'h00033330;
    bus_read(1, d); check("R10 word1 absent bits zero", d, 32'h00033330);
    bus_read(2, d); check("R10 empty address 2", d, 32'h0);
    bus_read(3, d); check("R10 empty address 3", d, 32'h0);
    check("R10 lines 4,5 level-high idle", 32'(irq[5:4]), 0);
    pins[5] = 1'b1;
    tick(2); check("R10 line5 is word1 bit1", 32'(irq[5:4]), 32'h2);
  endtask

  initial begin
    shadow[0] = 32'h0000F000;
    shadow[1] = 32'h00003000;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_level_high();
    t_level_low();
    t_rise();
    t_fall();
    t_both();
    t_mask();
    t_clear_level();
    t_race();
    t_regmap();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule